// File: doc/BRIEF.md
# Wide Sprite Data Latch with Bus-Residue Capture

This block holds the two data words (plane A and plane B) of one hardware sprite, each widened into four 16-bit slots for sprites up to 64 pixels wide. When a processor or copper write lands on a sprite data register, the written word is spread over all four slots. In the wide fetch modes the leading slot or slots do not keep that word. They take whatever was left on the shared chip bus, or a bitplane longword, instead.

To reproduce this, the block watches the bus traffic that leaves residue behind. It sees bitplane fetches (with plane index, longword and address bit 1), copper first-word reads, audio and disk DMA reads, and the point where a copper instruction finishes executing. From this it keeps a last-bus-word register and two 32-bit fetch copies per bitplane. On a data write it picks the residue source from the fetch-mode bits, the previous-slot DMA flag and the index of the plane fetched in the following slot. Slot k occupies bits [16k+15:16k] of each plane output.

Top module: `wide_sprite_latch`

## Requirements
- R1: A synchronous active-high `rst` sets every slot of both planes, the width code, the last-bus-word register and all per-plane fetch copies to zero.
- R2: With `fmode[3]`=0, a write puts the written word unchanged into all four slots of the selected plane.
- R3: With `fmode[3]`=1 and either `fmode[2]`=0 or `prev_slot_bpl`=0, a write fills slots 1..3 with the written word and slot 0 with the last-bus-word register as it stood before that clock edge.
- R4: With `fmode[3:2]`=2'b11 and `prev_slot_bpl`=1, a write fills slots 2..3 with the written word. It fills slot 0 with bits [31:16] and slot 1 with bits [15:0] of the stored fetch copy for plane `next_plane`.
- R5: For the R4 case, the source is the full-width fetch copy when `fmode[1:0]` is nonzero at write time. When `fmode[1:0]`=0 it is the sprite-path copy.
- R6: A bitplane fetch with `fmode[1:0]`=0 is a single fetch. Its data word is `bpl_data[15:0]` when `bpl_addr1`=1 and `bpl_data[31:16]` otherwise. The sprite-path copy becomes {low,low} when `bpl_addr1`=1 and the whole longword otherwise. The last-bus-word register takes the data word. With `fmode[1:0]`≠0 the full-width copy takes `bpl_data` and the last-bus-word register takes `bpl_data[15:0]`.
- R7: `bus_load` (copper first word, audio or disk DMA read) loads `bus_word` into the last-bus-word register. `cop_exec` loads `cop_exec_word`, the copper second word, when the instruction completes. Priority is bitplane fetch, then `cop_exec`, then `bus_load`. With no event the register holds.
- R8: Any write latches `fmode[3:2]` into `spr_width` (00 = 16, 01/10 = 32, 11 = 64 pixels). Without a write the code holds.
- R9: Writes to A and B in the same cycle are handled independently with their own values. A plane that is not written keeps all four slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_a | input | 1 | Write strobe for plane A data |
| wr_a_val | input | 16 | Value written to plane A |
| wr_b | input | 1 | Write strobe for plane B data |
| wr_b_val | input | 16 | Value written to plane B |
| fmode | input | 4 | Fetch-mode bits |
| prev_slot_bpl | input | 1 | Previous bus slot was bitplane DMA |
| next_plane | input | 3 | Plane fetched in the slot after the write |
| bpl_fetch | input | 1 | Bitplane fetch occurs this cycle |
| bpl_plane | input | 3 | Plane index of that fetch |
| bpl_data | input | 32 | Fetched longword |
| bpl_addr1 | input | 1 | Address bit 1 of the fetch |
| bus_load | input | 1 | Copper first-word, audio or disk read on the bus |
| bus_word | input | 16 | Word of that read |
| cop_exec | input | 1 | Copper instruction completes |
| cop_exec_word | input | 16 | Second word of the completed instruction |
| spr_a | output | 64 | Plane A slots, slot k at [16k+15:16k] |
| spr_b | output | 64 | Plane B slots |
| spr_width | output | 2 | Latched width code |

## Verification
The bench builds the block with its defaults: 16-bit words, four slots and eight bitplanes. With eight planes, residue can be stored in one plane and pulled through a different `next_plane`, so a wrong plane select shows up as a wrong slot pair. Four slots let the bench see both the slots that are replaced and the slots that keep the written word in every fetch-mode case.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
    typedef enum logic [1:0] {
        SUB_NONE = 2'd0,
        SUB_ONE  = 2'd1,
        SUB_TWO  = 2'd2
    } sub_mode_e;
endpackage

// File: rtl/wsl_residue_track.sv
module wsl_residue_track #(
    parameter int W       = 16,
    parameter int NPLANES = 8,
    parameter int PW      = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wide_fetch,
    input  logic           bpl_fetch,
    input  logic [PW-1:0]  bpl_plane,
    input  logic [2*W-1:0] bpl_data,
    input  logic           bpl_addr1,
    input  logic           bus_load,
    input  logic [W-1:0]   bus_word,
    input  logic           cop_exec,
    input  logic [W-1:0]   cop_exec_word,
    input  logic [PW-1:0]  rd_plane,
    output logic [W-1:0]   last_word,
    output logic [2*W-1:0] full_copy,
    output logic [2*W-1:0] spr_copy
);
    typedef struct packed {
        logic [W-1:0]                  last;
        logic [NPLANES-1:0][2*W-1:0]   full;
        logic [NPLANES-1:0][2*W-1:0]   spr;
    } trk_t;

    trk_t st_d, st_q;
    logic [W-1:0] lo_half, hi_half, single_word;

    assign lo_half     = bpl_data[W-1:0];
    assign hi_half     = bpl_data[2*W-1:W];
    assign single_word = bpl_addr1 ? lo_half : hi_half;

    always_comb begin
        st_d = st_q;
        if (bpl_fetch) begin
            if (wide_fetch) begin
                st_d.full[bpl_plane] = bpl_data;
                st_d.last            = lo_half;
            end else begin
                st_d.full[bpl_plane] = {{W{1'b0}}, single_word};
                st_d.spr[bpl_plane]  = bpl_addr1 ? {lo_half, lo_half} : bpl_data;
                st_d.last            = single_word;
            end
        end else if (cop_exec) begin
            st_d.last = cop_exec_word;
        end else if (bus_load) begin
            st_d.last = bus_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign last_word = st_q.last;
    assign full_copy = st_q.full[rd_plane];
    assign spr_copy  = st_q.spr[rd_plane];

    p_wide_last_r6: assert property (@(posedge clk) disable iff (rst)
        (bpl_fetch && wide_fetch) |=> (last_word == $past(bpl_data[W-1:0])));
    p_exec_last_r7: assert property (@(posedge clk) disable iff (rst)
        (cop_exec && !bpl_fetch) |=> (last_word == $past(cop_exec_word)));
    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!bpl_fetch && !cop_exec && !bus_load) |=> $stable(last_word));
endmodule

// File: rtl/wsl_slot_bank.sv
module wsl_slot_bank
    import wsl_pkg::*;
#(
    parameter int W     = 16,
    parameter int SLOTS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [W-1:0]     wr_val,
    input  sub_mode_e        mode,
    input  logic [W-1:0]     res16,
    input  logic [2*W-1:0]   res32,
    output logic [SLOTS*W-1:0] slots_o
);
    typedef struct packed {
        logic [SLOTS-1:0][W-1:0] slot;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (wr) begin
            for (int k = 0; k < SLOTS; k++) bk_d.slot[k] = wr_val;
            case (mode)
                SUB_ONE: bk_d.slot[0] = res16;
                SUB_TWO: begin
                    bk_d.slot[0] = res32[2*W-1:W];
                    bk_d.slot[1] = res32[W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bk_q <= '0;
        else     bk_q <= bk_d;
    end

    assign slots_o = bk_q.slot;

    p_plain_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && mode == SUB_NONE) |=> (slots_o == {SLOTS{$past(wr_val)}}));
    p_pair_sub_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && mode == SUB_TWO) |=> (slots_o[2*W-1:0] == {$past(res32[W-1:0]), $past(res32[2*W-1:W])}));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(slots_o));
endmodule

// File: rtl/wide_sprite_latch.sv
module wide_sprite_latch
    import wsl_pkg::*;
#(
    parameter int W       = 16,
    parameter int SLOTS   = 4,
    parameter int NPLANES = 8,
    localparam int PW     = (NPLANES > 1) ? $clog2(NPLANES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_a,
    input  logic [W-1:0]       wr_a_val,
    input  logic               wr_b,
    input  logic [W-1:0]       wr_b_val,
    input  logic [3:0]         fmode,
    input  logic               prev_slot_bpl,
    input  logic [PW-1:0]      next_plane,
    input  logic               bpl_fetch,
    input  logic [PW-1:0]      bpl_plane,
    input  logic [2*W-1:0]     bpl_data,
    input  logic               bpl_addr1,
    input  logic               bus_load,
    input  logic [W-1:0]       bus_word,
    input  logic               cop_exec,
    input  logic [W-1:0]       cop_exec_word,
    output logic [SLOTS*W-1:0] spr_a,
    output logic [SLOTS*W-1:0] spr_b,
    output logic [1:0]         spr_width
);
    logic [W-1:0]   last_word;
    logic [2*W-1:0] full_copy, spr_copy, res32;
    sub_mode_e      mode;
    logic [1:0]     width_d, width_q;

    wsl_residue_track #(.W(W), .NPLANES(NPLANES), .PW(PW)) u_track (
        .clk           (clk),
        .rst           (rst),
        .wide_fetch    (|fmode[1:0]),
        .bpl_fetch     (bpl_fetch),
        .bpl_plane     (bpl_plane),
        .bpl_data      (bpl_data),
        .bpl_addr1     (bpl_addr1),
        .bus_load      (bus_load),
        .bus_word      (bus_word),
        .cop_exec      (cop_exec),
        .cop_exec_word (cop_exec_word),
        .rd_plane      (next_plane),
        .last_word     (last_word),
        .full_copy     (full_copy),
        .spr_copy      (spr_copy)
    );

    always_comb begin
        if (!fmode[3])                   mode = SUB_NONE;
        else if (fmode[2] && prev_slot_bpl) mode = SUB_TWO;
        else                             mode = SUB_ONE;
        res32   = (|fmode[1:0]) ? full_copy : spr_copy;
        width_d = (wr_a || wr_b) ? fmode[3:2] : width_q;
    end

    always_ff @(posedge clk) begin
        if (rst) width_q <= '0;
        else     width_q <= width_d;
    end

    assign spr_width = width_q;

    logic [1:0]           wr_vec;
    logic [1:0][W-1:0]    val_vec;
    logic [1:0][SLOTS*W-1:0] out_vec;

    assign wr_vec  = {wr_b, wr_a};
    assign val_vec = {wr_b_val, wr_a_val};

    for (genvar g = 0; g < 2; g++) begin : g_plane
        wsl_slot_bank #(.W(W), .SLOTS(SLOTS)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr_vec[g]),
            .wr_val  (val_vec[g]),
            .mode    (mode),
            .res16   (last_word),
            .res32   (res32),
            .slots_o (out_vec[g])
        );
    end

    assign spr_a = out_vec[0];
    assign spr_b = out_vec[1];

    p_bus_residue_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_a && fmode[3] && !prev_slot_bpl) |=> (spr_a[W-1:0] == $past(last_word)));
    p_width_latch_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_a || wr_b) |=> (spr_width == $past(fmode[3:2])));
    p_width_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!wr_a && !wr_b) |=> $stable(spr_width));
endmodule

// File: tb/sim_wide_sprite_latch.sv
module sim_wide_sprite_latch;
    logic        clk = 0;
    logic        rst;
    logic        wr_a, wr_b, prev_slot_bpl, bpl_fetch, bpl_addr1, bus_load, cop_exec;
    logic [15:0] wr_a_val, wr_b_val, bus_word, cop_exec_word;
    logic [3:0]  fmode;
    logic [2:0]  next_plane, bpl_plane;
    logic [31:0] bpl_data;
    logic [63:0] spr_a, spr_b;
    logic [1:0]  spr_width;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [15:0] m_last;
    logic [31:0] m_full [8];
    logic [31:0] m_spr  [8];
    logic [63:0] m_a, m_b;
    logic [1:0]  m_w;

    always #10 clk = ~clk;

    wide_sprite_latch u0 (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_a = 0; wr_b = 0; wr_a_val = 0; wr_b_val = 0;
        prev_slot_bpl = 0; next_plane = 0; bpl_fetch = 0; bpl_plane = 0;
        bpl_data = 0; bpl_addr1 = 0; bus_load = 0; bus_word = 0;
        cop_exec = 0; cop_exec_word = 0;
    endtask

    task automatic model_reset();
        m_last = 0; m_a = 0; m_b = 0; m_w = 0;
        for (int i = 0; i < 8; i++) begin m_full[i] = 0; m_spr[i] = 0; end
    endtask

    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check_outputs(string req);
        check({req, " plane A"}, spr_a, m_a);
        check({req, " plane B"}, spr_b, m_b);
        check({req, " width"}, {62'd0, spr_width}, {62'd0, m_w});
    endtask

    // R6: record a bitplane fetch, fm sets single or wide behaviour
    task automatic fetch(logic [3:0] fm, logic [2:0] pl, logic [31:0] d, logic a1);
        logic [15:0] wd;
        fmode = fm; bpl_fetch = 1; bpl_plane = pl; bpl_data = d; bpl_addr1 = a1;
        if (fm[1:0] != 0) begin
            m_full[pl] = d; m_last = d[15:0];
        end else begin
            wd = a1 ? d[15:0] : d[31:16];
            m_full[pl] = {16'd0, wd};
            m_spr[pl]  = a1 ? {d[15:0], d[15:0]} : d;
            m_last = wd;
        end
        tick();
    endtask

    function automatic logic [63:0] fill(logic [15:0] v, logic [1:0] md,
                                         logic [15:0] r16, logic [31:0] r32);
        logic [63:0] s;
        s = {4{v}};
        if (md == 1) s[15:0] = r16;
        if (md == 2) s[31:0] = {r32[15:0], r32[31:16]};
        return s;
    endfunction

    task automatic write(logic ea, logic eb, logic [15:0] va, logic [15:0] vb,
                         logic [3:0] fm, logic pv, logic [2:0] np, string req);
        logic [1:0]  md;
        logic [31:0] r32;
        fmode = fm; prev_slot_bpl = pv; next_plane = np;
        wr_a = ea; wr_b = eb; wr_a_val = va; wr_b_val = vb;
        md  = !fm[3] ? 2'd0 : ((fm[2] && pv) ? 2'd2 : 2'd1);
        r32 = (fm[1:0] != 0) ? m_full[np] : m_spr[np];
        if (ea) m_a = fill(va, md, m_last, r32);
        if (eb) m_b = fill(vb, md, m_last, r32);
        if (ea || eb) m_w = fm[3:2];
        tick();
        check_outputs(req);
    endtask

    task automatic t_reset();
        rst = 1; tick(); tick(); rst = 0;
        model_reset();
        check_outputs("R1 reset");
    endtask

    task automatic t_plain();
        write(1, 1, 16'h1234, 16'hABCD, 4'b0000, 0, 0, "R2 narrow mode");
        write(1, 0, 16'h5A5A, 16'h0000, 4'b0011, 1, 2, "R2 bit3 clear ignores dma flag");
    endtask

    task automatic t_bus_residue();
        bus_load = 1; bus_word = 16'hC0DE; m_last = 16'hC0DE; tick();
        write(1, 0, 16'h1111, 0, 4'b1000, 0, 0, "R3 R7 bus word residue");
        write(0, 1, 16'h2222, 0, 4'b1000, 1, 0, "R3 bit2 clear with dma");
        write(1, 1, 16'h3333, 16'h4444, 4'b1100, 0, 0, "R3 R9 no prior dma");
    endtask

    task automatic t_bpl_residue();
        fetch(4'b0000, 3'd5, 32'hDEAD_BEEF, 1);
        fetch(4'b0000, 3'd2, 32'hCAFE_F00D, 0);
        write(1, 0, 16'h7777, 0, 4'b1100, 1, 5, "R4 R6 single fetch addr1 set");
        write(0, 1, 16'h8888, 0, 4'b1100, 1, 2, "R4 R6 single fetch addr1 clear");
        write(1, 0, 16'h9999, 0, 4'b1000, 0, 0, "R6 single fetch last word");
        fetch(4'b0011, 3'd5, 32'h0BAD_F00D, 0);
        write(1, 0, 16'hAAAA, 0, 4'b1111, 1, 5, "R5 wide fetch source");
        write(0, 1, 16'hBBBB, 0, 4'b1100, 1, 5, "R5 sprite copy source");
        write(1, 0, 16'hCCCC, 0, 4'b1001, 0, 0, "R6 wide fetch last word");
    endtask

    task automatic t_priority();
        cop_exec = 1; cop_exec_word = 16'h0E0E; bus_load = 1; bus_word = 16'h0B0B;
        m_last = 16'h0E0E; tick();
        write(1, 0, 16'h1010, 0, 4'b1000, 0, 0, "R7 exec over bus word");
        fmode = 4'b0001; bpl_fetch = 1; bpl_plane = 3'd1; bpl_data = 32'h1357_2468;
        cop_exec = 1; cop_exec_word = 16'hFFFF;
        m_full[1] = 32'h1357_2468; m_last = 16'h2468; tick();
        write(0, 1, 16'h2020, 0, 4'b1000, 0, 0, "R7 fetch over exec");
    endtask

    task automatic t_hold();
        fmode = 4'b1111; tick(); tick();
        check_outputs("R8 R9 hold without write");
        write(0, 1, 16'h4242, 16'h6161, 4'b0100, 0, 0, "R9 A untouched by B write");
    endtask

    initial begin
        idle_inputs(); fmode = 0; rst = 1;
        model_reset();
        t_reset();
        t_plain();
        t_bus_residue();
        t_bpl_residue();
        t_priority();
        t_hold();
        t_reset();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule